// File: doc/BRIEF.md
# Restoring Serial Unsigned Divider

This block divides one unsigned W-bit integer by another (W defaults to 4) and returns a W-bit quotient and a W-bit remainder. It works one quotient bit at a time. A working remainder register that is one bit wider than the operands lets the sign of every trial subtraction be seen. Each step shifts the remainder and dividend pair left by one place and subtracts the divisor. When that subtraction goes negative, the divisor is added back in a separate clock cycle. The new quotient bit is the complement of the sign of the trial result.

A request is one cycle of `start_i` with the operands present. The block raises `busy_o` until the operation completes and then pulses `done_o` with the results on `quot_o` and `rem_o`. Those results stay put until the next accepted request. A zero divisor skips the iterations and completes at once with `dbz_o` raised.

Top module: `restoring_divider`

## Requirements
- R1: While reset is held and after its release, `busy_o`, `done_o` and `dbz_o` are low and `quot_o` and `rem_o` are zero.
- R2: With a nonzero divisor, `quot_o` equals floor(dividend / divisor) and `rem_o` equals dividend mod divisor, both unsigned, in the cycle where `done_o` is high. The remainder is therefore always below the divisor.
- R3: With a nonzero divisor, `done_o` goes high exactly 3·W + Z rising edges after the edge that accepts `start_i`, where Z is the number of zero bits in the quotient. Every zero quotient bit costs one extra restore cycle.
- R4: `done_o` is high for exactly one cycle. `busy_o` is high from the edge that accepts a request through the `done_o` cycle inclusive, and low otherwise.
- R5: `start_i` is ignored while `busy_o` is high. A request in flight keeps its operands, its result and its latency.
- R6: A zero divisor completes one edge after acceptance. `done_o` and `dbz_o` are then high together, `quot_o` is all ones and `rem_o` equals the dividend. `dbz_o` is never high without `done_o`.
- R7: After `done_o`, `quot_o` and `rem_o` hold their values until the next accepted `start_i`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Request; accepted only while idle |
| dividend_i | input | W | Unsigned dividend, sampled on acceptance |
| divisor_i | input | W | Unsigned divisor, sampled on acceptance |
| busy_o | output | 1 | Operation in progress, including the done cycle |
| done_o | output | 1 | One-cycle completion pulse |
| dbz_o | output | 1 | Divisor was zero; high only together with done_o |
| quot_o | output | W | Quotient |
| rem_o | output | W | Remainder |

## Verification
The hardest case to reach from the ports is a request that arrives while a division is already running. Such a request must leave the operands in flight, the result and the restore-dependent latency all untouched. The stimulus pulses `start_i` with different operands in the middle of selected divisions and checks both the result and the exact completion edge against the original operands. Random operand pairs from a fixed seed cover every mix of restoring and non-restoring steps. Directed cases add zero divisors, a zero dividend, a divisor larger than the dividend, and full-scale values.

// File: rtl/rdiv_pkg.sv
package rdiv_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SHIFT,
    ST_SUB,
    ST_RESTORE,
    ST_NEXT,
    ST_DONE
  } rdiv_state_e;
endpackage

// File: rtl/rdiv_ctrl.sv
module rdiv_ctrl
  import rdiv_pkg::*;
#(
  parameter int W = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  input  logic div_zero_i,
  input  logic trial_neg_i,
  output logic ld_o,
  output logic ld_dbz_o,
  output logic shift_o,
  output logic sub_o,
  output logic restore_o,
  output logic at_next_o,
  output logic busy_o,
  output logic done_o,
  output logic dbz_o
);
  localparam int CW = $clog2(W + 1);

  rdiv_state_e state_q, state_d;
  logic [CW-1:0] cnt_q;
  logic          dbz_q;
  logic          last_iter;

  assign last_iter = (cnt_q == CW'(W - 1));

  always_comb begin
    state_d   = state_q;
    ld_o      = 1'b0;
    ld_dbz_o  = 1'b0;
    shift_o   = 1'b0;
    sub_o     = 1'b0;
    restore_o = 1'b0;
    case (state_q)
      ST_IDLE: if (start_i) begin
        ld_o = 1'b1;
        if (div_zero_i) begin
          ld_dbz_o = 1'b1;
          state_d  = ST_DONE;
        end else begin
          state_d = ST_SHIFT;
        end
      end
      ST_SHIFT: begin
        shift_o = 1'b1;
        state_d = ST_SUB;
      end
      ST_SUB: begin
        sub_o   = 1'b1;
        state_d = trial_neg_i ? ST_RESTORE : ST_NEXT;
      end
      ST_RESTORE: begin
        restore_o = 1'b1;
        state_d   = ST_NEXT;
      end
      ST_NEXT: state_d = last_iter ? ST_DONE : ST_SHIFT;
      ST_DONE: state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      dbz_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      if (ld_o) begin
        cnt_q <= '0;
        dbz_q <= ld_dbz_o;
      end else if (state_q == ST_NEXT) begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign at_next_o = (state_q == ST_NEXT);
  assign busy_o    = (state_q != ST_IDLE);
  assign done_o    = (state_q == ST_DONE);
  assign dbz_o     = done_o & dbz_q;

  p_done_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);
  p_dbz_only_done_r6: assert property (@(posedge clk) disable iff (!rst_n)
    dbz_o |-> done_o);
  p_iter_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CW'(W));
  p_neg_restores_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (sub_o && trial_neg_i) |=> restore_o);
  p_busy_after_accept_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ld_o |=> busy_o);
endmodule

// File: rtl/rdiv_datapath.sv
module rdiv_datapath #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         ld_i,
  input  logic         ld_dbz_i,
  input  logic         shift_i,
  input  logic         sub_i,
  input  logic         restore_i,
  input  logic [W-1:0] dividend_i,
  input  logic [W-1:0] divisor_i,
  output logic         trial_neg_o,
  output logic         a_msb_o,
  output logic [W-1:0] m_low_o,
  output logic [W-1:0] quot_o,
  output logic [W-1:0] rem_o
);
  localparam int AW = W + 1;

  logic [AW-1:0] a_q, m_q, diff;
  logic [W-1:0]  q_q;

  function automatic logic [AW-1:0] f_trial(input logic [AW-1:0] a, input logic [AW-1:0] m);
    return a - m;
  endfunction

  function automatic logic [AW-1:0] f_restore(input logic [AW-1:0] a, input logic [AW-1:0] m);
    return a + m;
  endfunction

  assign diff        = f_trial(a_q, m_q);
  assign trial_neg_o = diff[AW-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_q <= '0;
      m_q <= '0;
      q_q <= '0;
    end else if (ld_i) begin
      m_q <= {1'b0, divisor_i};
      if (ld_dbz_i) begin
        a_q <= {1'b0, dividend_i};
        q_q <= '1;
      end else begin
        a_q <= '0;
        q_q <= dividend_i;
      end
    end else if (shift_i) begin
      {a_q, q_q} <= {a_q[AW-2:0], q_q, 1'b0};
    end else if (sub_i) begin
      a_q    <= diff;
      q_q[0] <= ~diff[AW-1];
    end else if (restore_i) begin
      a_q <= f_restore(a_q, m_q);
    end
  end

  assign a_msb_o = a_q[AW-1];
  assign m_low_o = m_q[W-1:0];
  assign quot_o  = q_q;
  assign rem_o   = a_q[W-1:0];

  p_m_top_clear_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !m_q[AW-1]);
  p_restore_nonneg_r2: assert property (@(posedge clk) disable iff (!rst_n)
    restore_i |=> !a_q[AW-1]);
  p_shift_keeps_m_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (shift_i || sub_i || restore_i) |=> $stable(m_q));
endmodule

// File: rtl/restoring_divider.sv
module restoring_divider #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start_i,
  input  logic [W-1:0] dividend_i,
  input  logic [W-1:0] divisor_i,
  output logic         busy_o,
  output logic         done_o,
  output logic         dbz_o,
  output logic [W-1:0] quot_o,
  output logic [W-1:0] rem_o
);
  logic ld, ld_dbz, shift, sub, restore, at_next;
  logic trial_neg, a_msb;
  logic [W-1:0] m_low;

  rdiv_ctrl #(.W(W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .start_i(start_i),
    .div_zero_i(divisor_i == '0), .trial_neg_i(trial_neg),
    .ld_o(ld), .ld_dbz_o(ld_dbz), .shift_o(shift), .sub_o(sub),
    .restore_o(restore), .at_next_o(at_next),
    .busy_o(busy_o), .done_o(done_o), .dbz_o(dbz_o)
  );

  rdiv_datapath #(.W(W)) u_dp (
    .clk(clk), .rst_n(rst_n), .ld_i(ld), .ld_dbz_i(ld_dbz),
    .shift_i(shift), .sub_i(sub), .restore_i(restore),
    .dividend_i(dividend_i), .divisor_i(divisor_i),
    .trial_neg_o(trial_neg), .a_msb_o(a_msb), .m_low_o(m_low),
    .quot_o(quot_o), .rem_o(rem_o)
  );

  p_rem_below_div_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && !dbz_o) |-> (rem_o < m_low));
  p_step_nonneg_r2: assert property (@(posedge clk) disable iff (!rst_n)
    at_next |-> !a_msb);
  p_results_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_o && !start_i) |=> ($stable(quot_o) && $stable(rem_o)));
  p_divisor_fixed_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && !done_o) |=> $stable(m_low));
endmodule

// File: tb/restoring_divider_test.sv
module restoring_divider_test;
  localparam int W = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start_i = 1'b0;
  logic [W-1:0] dividend_i = '0, divisor_i = '0;
  logic busy_o, done_o, dbz_o;
  logic [W-1:0] quot_o, rem_o;

  int n_tests = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  restoring_divider #(.W(W)) uut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i),
    .dividend_i(dividend_i), .divisor_i(divisor_i),
    .busy_o(busy_o), .done_o(done_o), .dbz_o(dbz_o),
    .quot_o(quot_o), .rem_o(rem_o)
  );

  function automatic int exp_quot(int a, int b);
    if (b == 0) return (1 << W) - 1;
    return a / b;
  endfunction

  function automatic int exp_rem(int a, int b);
    if (b == 0) return a;
    return a % b;
  endfunction

  function automatic int exp_edges(int a, int b);
    int q, zeros;
    if (b == 0) return 1;
    q = a / b;
    zeros = 0;
    for (int i = 0; i < W; i++) if (((q >> i) & 1) == 0) zeros++;
    return 1 + 3 * W + zeros;
  endfunction

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic run_op(input int a, input int b, input bit poke);
    int edges;
    bit busy_ok;
    @(negedge clk);
    start_i = 1'b1;
    dividend_i = W'(a);
    divisor_i = W'(b);
    @(negedge clk);
    start_i = 1'b0;
    edges = 1;
    busy_ok = 1'b1;
    while (!done_o && edges < 100) begin
      if (!busy_o) busy_ok = 1'b0;
      if (poke && edges == 3) begin
        start_i = 1'b1;
        dividend_i = W'(a ^ 5);
        divisor_i = W'(b ^ 3);
      end
      @(negedge clk);
      start_i = 1'b0;
      dividend_i = W'(a ^ 9);
      divisor_i = W'(b ^ 6);
      edges++;
    end
    check(busy_ok && busy_o, poke ? "R5 busy through op" : "R4 busy through op", busy_o, 1);
    check(edges == exp_edges(a, b), poke ? "R5 latency" : (b == 0 ? "R6 latency" : "R3 latency"),
          edges, exp_edges(a, b));
    check(int'(quot_o) == exp_quot(a, b), poke ? "R5 quotient" : (b == 0 ? "R6 quotient" : "R2 quotient"),
          quot_o, exp_quot(a, b));
    check(int'(rem_o) == exp_rem(a, b), poke ? "R5 remainder" : (b == 0 ? "R6 remainder" : "R2 remainder"),
          rem_o, exp_rem(a, b));
    check(dbz_o == (b == 0), "R6 dbz flag", dbz_o, b == 0);
    @(negedge clk);
    check(!done_o && !busy_o && !dbz_o, "R4 done single pulse", done_o, 0);
    @(negedge clk);
    @(negedge clk);
    check(int'(quot_o) == exp_quot(a, b) && int'(rem_o) == exp_rem(a, b),
          "R7 results held", quot_o, exp_quot(a, b));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(!busy_o && !done_o && !dbz_o && quot_o == 0 && rem_o == 0, "R1 reset state", busy_o, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(!busy_o && !done_o && quot_o == 0 && rem_o == 0, "R1 after release", quot_o, 0);

    run_op(7, 3, 1'b0);
    run_op(15, 1, 1'b0);
    run_op(0, 5, 1'b0);
    run_op(15, 15, 1'b0);
    run_op(3, 7, 1'b0);
    run_op(14, 2, 1'b0);
    run_op(9, 0, 1'b0);
    run_op(0, 0, 1'b0);
    run_op(15, 0, 1'b0);
    run_op(13, 4, 1'b1);
    run_op(7, 3, 1'b1);
    run_op(6, 0, 1'b1);

    void'($urandom(32'd2718));
    for (int i = 0; i < 300; i++) begin
      int a, b;
      a = int'($urandom_range((1 << W) - 1, 0));
      b = int'($urandom_range((1 << W) - 1, 0));
      run_op(a, b, (i % 7) == 3);
    end
    finished = 1'b1;
  end

  initial begin
    int cycles;
    cycles = 0;
    while (!finished && cycles < 150000) begin
      @(posedge clk);
      cycles++;
    end
    if (!finished) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 0);
    end
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule